// File: doc/BRIEF.md
# Four-Channel PWM Timer

This block is a pulse-width modulation timer with four channels. A single counter runs either continuously or for one counter period. A 4-bit prescale picks which 8-bit window of the counter the four comparators see. Each comparator drives one PWM output and one interrupt-pending flag. The pending flags appear directly on the interrupt lines.

One configuration word holds all the mode controls. They cover run mode, return-to-zero on a channel-0 match, centre-aligned comparison per channel, and pairing of each channel with its neighbour so that it gives a window pulse. They also set whether pending flags are sticky against software and whether they are held only until the counter period ends.

Software reaches the configuration word, the counter, a read-only scaled-count view and the four compare values through a simple word-addressed register bus. Writes take effect on the clock edge. Reads are combinational.

Top module: `pwm_timer`

## Requirements
- R1: While reset is asserted, the configuration word (offset 0x00) and the counter (offset 0x08) read 0, `irq` is 0, and with all compare values at 0 `pwm_out` is 4'hF.
- R2: The counter advances by one per clock only while configuration bit 12 (continuous) or bit 13 (one-shot) is set, and holds otherwise. A bus write to offset 0x08 loads the counter and takes priority over advancing.
- R3: Offset 0x10 reads the scaled count, which is (counter >> config[3:0]) truncated to 8 bits. Writes to 0x10 are ignored.
- R4: Compare value i is 8 bits at offset 0x20 + 4*i. Output `pwm_out[i]` is high while the channel's compare input is greater than or equal to compare value i.
- R5: A running counter whose bits below position prescale+8 are all ones returns to 0 on the next clock. This ends a counter period.
- R6: With configuration bit 9 set, a running counter whose scaled count is at least compare value 0 returns to 0 on the next clock. This also ends a counter period.
- R7: Configuration bit 13 clears itself at the end of a counter period, after which the counter stays at 0.
- R8: Configuration bit 16+i makes channel i centre-aligned. When the scaled count's bit 7 is set, the channel compares the bitwise inverse of the scaled count.
- R9: Configuration bit 24+i pairs channel i with channel (i+1) mod 4. The output of channel i is then its own compare result AND NOT the next channel's compare result.
- R10: Pending flag i (configuration bit 28+i, driven on `irq[i]`) is set on the clock after channel i's compare result, taken before pairing, is true. When bit 8 is clear, a configuration write loads the flags from the written bits 31:28.
- R11: With configuration bit 8 (sticky) set, configuration writes do not change the pending flags.
- R12: With configuration bit 10 (deglitch) set, all pending flags clear at the end of every counter period. This clear takes priority over setting.
- R13: When a software write to the flags and a compare hit fall in the same cycle, the hardware set wins and the flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_out | output | 4 | PWM outputs, one per channel |
| irq | output | 4 | Pending flags, one per channel |

## Verification
Two things can hit a pending flag in the same cycle. One is a software configuration write that clears the flags. The other is a compare hit or a period-end clear. The bench parks the counter above compare value 0 and writes zeros to the flag field. It samples `irq` half a cycle after that edge, where a lost set would show as 0.

For deglitch, the bench uses sticky together with deglitch so that only the period-end clear can remove the flag. It then runs the counter through a wrap and compares the result against a sticky-only run over the same window, in which the flag has to survive.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int PWM_NCH   = 4;
    localparam int PWM_SCL_W = 4;

    localparam logic [7:0] OFS_CFG = 8'h00;
    localparam logic [7:0] OFS_CNT = 8'h08;
    localparam logic [7:0] OFS_SCL = 8'h10;
    localparam logic [7:0] OFS_CMP = 8'h20;

    // configuration bit positions (software visible)
    localparam int B_STICKY  = 8;
    localparam int B_ZERO    = 9;
    localparam int B_DEGL    = 10;
    localparam int B_ALWAYS  = 12;
    localparam int B_ONESHOT = 13;
    localparam int B_CENTER  = 16;
    localparam int B_GANG    = 24;
    localparam int B_PEND    = 28;

    typedef struct packed {
        logic [PWM_NCH-1:0]   gang;
        logic [PWM_NCH-1:0]   center;
        logic                 en_always;
        logic                 deglitch;
        logic                 zero_on_match;
        logic                 sticky;
        logic [PWM_SCL_W-1:0] scale;
    } cfg_t;

endpackage

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
    parameter int CMP_W = 8
) (
    input  logic [CMP_W-1:0] scaled,
    input  logic [CMP_W-1:0] thresh,
    input  logic             center,
    output logic             hit
);
    logic [CMP_W-1:0] view;

    always_comb begin
        // centre mode folds the upper half of the window back down
        view = (center && scaled[CMP_W-1]) ? ~scaled : scaled;
        hit  = (view >= thresh);
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 23,
    parameter int CMP_W = 8,
    parameter int SCL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_always,
    input  logic             zero_on_match,
    input  logic [SCL_W-1:0] scale,
    input  logic [CMP_W-1:0] ref0,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             os_wr,
    input  logic             os_val,
    output logic [CNT_W-1:0] count,
    output logic [CMP_W-1:0] scaled,
    output logic             oneshot,
    output logic             cyc_end
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             oneshot;
    } cnt_st_t;

    cnt_st_t    st_d, st_q;
    logic       run;
    logic       wrap;
    logic       hit0;
    logic [CNT_W:0] lim;
    int         shamt;

    always_comb begin
        run    = en_always | st_q.oneshot;
        scaled = CMP_W'(st_q.count >> scale);
        shamt  = int'(scale) + CMP_W;
        lim    = ({{CNT_W{1'b0}}, 1'b1} << shamt) - 1'b1;
        wrap   = (st_q.count & lim[CNT_W-1:0]) == lim[CNT_W-1:0];
        hit0   = (scaled >= ref0);
        cyc_end = run && (wrap || (zero_on_match && hit0));

        st_d = st_q;
        if (load)         st_d.count = load_val;
        else if (cyc_end) st_d.count = '0;
        else if (run)     st_d.count = st_q.count + 1'b1;

        if (os_wr)        st_d.oneshot = os_val;
        else if (cyc_end) st_d.oneshot = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.count;
    assign oneshot = st_q.oneshot;

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cyc_end && !load) |=> st_q.count == CNT_W'($past(st_q.count) + 1'b1));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(st_q.count));
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wrap && !load) |=> st_q.count == '0);
    p_match_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && zero_on_match && hit0 && !load) |=> st_q.count == '0);
    p_oneshot_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && !os_wr) |=> !st_q.oneshot);
endmodule

// File: rtl/pwm_pend.sv
module pwm_pend #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit,
    input  logic           sticky,
    input  logic           deglitch,
    input  logic           cyc_end,
    input  logic           sw_wr,
    input  logic [NCH-1:0] sw_val,
    output logic [NCH-1:0] ip
);
    logic [NCH-1:0] ip_d, ip_q;
    logic           flush;

    always_comb begin
        flush = deglitch && cyc_end;
        ip_d  = ip_q;
        if (sw_wr && !sticky) ip_d = sw_val;
        ip_d = ip_d | hit;            // hardware set beats software write
        if (flush) ip_d = '0;         // period end beats everything
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ip_q <= '0;
        else        ip_q <= ip_d;
    end

    assign ip = ip_q;

    p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !flush) |=> ((ip_q & $past(ip_q)) == $past(ip_q)));
    p_deglitch_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ip_q == '0);
    p_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> ((ip_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CMP_W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic [7:0]   bus_addr,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    output logic [3:0]   pwm_out,
    output logic [3:0]   irq
);
    localparam int NCH   = PWM_NCH;
    localparam int CNT_W = CMP_W + (1 << PWM_SCL_W) - 1;

    typedef struct packed {
        cfg_t                      cfg;
        logic [NCH-1:0][CMP_W-1:0] cmp;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             cfg_wr, cnt_wr;
    logic [CNT_W-1:0] count;
    logic [CMP_W-1:0] scaled;
    logic             oneshot, cyc_end;
    logic [NCH-1:0]   hit, ip;
    logic [NCH-1:0]   pwm_w;
    logic             unused_bits;

    assign cfg_wr = bus_we && (bus_addr == OFS_CFG);
    assign cnt_wr = bus_we && (bus_addr == OFS_CNT);
    assign unused_bits = ^{bus_wdata[23:20], bus_wdata[15:14], bus_wdata[11], bus_wdata[7:4]};

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.cfg.scale         = bus_wdata[PWM_SCL_W-1:0];
            st_d.cfg.sticky        = bus_wdata[B_STICKY];
            st_d.cfg.zero_on_match = bus_wdata[B_ZERO];
            st_d.cfg.deglitch      = bus_wdata[B_DEGL];
            st_d.cfg.en_always     = bus_wdata[B_ALWAYS];
            st_d.cfg.center        = bus_wdata[B_CENTER +: NCH];
            st_d.cfg.gang          = bus_wdata[B_GANG +: NCH];
        end
        for (int i = 0; i < NCH; i++) begin
            if (bus_we && bus_addr == 8'(int'(OFS_CMP) + 4 * i))
                st_d.cmp[i] = bus_wdata[CMP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pwm_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCL_W(PWM_SCL_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_always     (st_q.cfg.en_always),
        .zero_on_match (st_q.cfg.zero_on_match),
        .scale         (st_q.cfg.scale),
        .ref0          (st_q.cmp[0]),
        .load          (cnt_wr),
        .load_val      (bus_wdata[CNT_W-1:0]),
        .os_wr         (cfg_wr),
        .os_val        (bus_wdata[B_ONESHOT]),
        .count         (count),
        .scaled        (scaled),
        .oneshot       (oneshot),
        .cyc_end       (cyc_end)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_cmp #(.CMP_W(CMP_W)) u_cmp (
            .scaled (scaled),
            .thresh (st_q.cmp[g]),
            .center (st_q.cfg.center[g]),
            .hit    (hit[g])
        );
        assign pwm_w[g] = st_q.cfg.gang[g] ? (hit[g] & ~hit[(g + 1) % NCH]) : hit[g];
    end

    pwm_pend #(.NCH(NCH)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .sticky   (st_q.cfg.sticky),
        .deglitch (st_q.cfg.deglitch),
        .cyc_end  (cyc_end),
        .sw_wr    (cfg_wr),
        .sw_val   (bus_wdata[B_PEND +: NCH]),
        .ip       (ip)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CFG: begin
                bus_rdata[PWM_SCL_W-1:0]   = st_q.cfg.scale;
                bus_rdata[B_STICKY]        = st_q.cfg.sticky;
                bus_rdata[B_ZERO]          = st_q.cfg.zero_on_match;
                bus_rdata[B_DEGL]          = st_q.cfg.deglitch;
                bus_rdata[B_ALWAYS]        = st_q.cfg.en_always;
                bus_rdata[B_ONESHOT]       = oneshot;
                bus_rdata[B_CENTER +: NCH] = st_q.cfg.center;
                bus_rdata[B_GANG +: NCH]   = st_q.cfg.gang;
                bus_rdata[B_PEND +: NCH]   = ip;
            end
            OFS_CNT: bus_rdata = 32'(count);
            OFS_SCL: bus_rdata = 32'(scaled);
            default: begin
                for (int i = 0; i < NCH; i++)
                    if (bus_addr == 8'(int'(OFS_CMP) + 4 * i))
                        bus_rdata = 32'(st_q.cmp[i]);
            end
        endcase
    end

    assign pwm_out = pwm_w;
    assign irq     = ip;

    p_gang_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg.gang[0] |-> !(pwm_out[0] && hit[1]));
    p_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.gang == '0 && st_q.cfg.center == '0) |-> (pwm_out == hit));
endmodule

// File: tb/sim_pwm_timer.sv
module sim_pwm_timer;
    localparam int CLK_PERIOD = 10;
    localparam int RUN  = 1 << 12;
    localparam int ONES = 1 << 13;
    localparam int STK  = 1 << 8;
    localparam int ZER  = 1 << 9;
    localparam int DGL  = 1 << 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out, irq;

    int checks = 0;
    int fails  = 0;
    int cmpv[4];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = 8'(a);
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic run_for(input int n, input int base);
        wr(0, base | RUN);
        repeat (n - 2) @(negedge clk);
        wr(0, base);
    endtask

    task automatic set_cmps(input int c0, input int c1, input int c2, input int c3);
        cmpv[0] = c0; cmpv[1] = c1; cmpv[2] = c2; cmpv[3] = c3;
        for (int i = 0; i < 4; i++) wr(32 + 4 * i, cmpv[i]);
    endtask

    function automatic bit hitf(int s, int c, bit ctr);
        int v;
        v = (ctr && s[7]) ? ((~s) & 255) : s;
        return v >= c;
    endfunction

    task automatic sweep(input int cfgv, input string req);
        int ctr, gng, exp;
        bit h[4];
        ctr = (cfgv >> 16) & 15;
        gng = (cfgv >> 24) & 15;
        wr(0, cfgv);
        for (int v = 0; v < 256; v++) begin
            wr(8, v);
            exp = 0;
            for (int i = 0; i < 4; i++) h[i] = hitf(v, cmpv[i], ctr[i]);
            for (int i = 0; i < 4; i++)
                if (gng[i] ? (h[i] && !h[(i + 1) % 4]) : h[i]) exp |= (1 << i);
            check(pwm_out == 4'(exp), req, int'(pwm_out), exp);
        end
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v;
        // R1: reset state
        repeat (3) @(negedge clk);
        rd(0, v);  check(v == 0, "R1 cfg", v, 0);
        rd(8, v);  check(v == 0, "R1 count", v, 0);
        check(irq == 4'h0, "R1 irq", int'(irq), 0);
        check(pwm_out == 4'hF, "R1 pwm", int'(pwm_out), 15);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: counting, hold, load
        wr(8, 100);
        rd(8, v);  check(v == 100, "R2 load", v, 100);
        repeat (5) @(negedge clk);
        rd(8, v);  check(v == 100, "R2 idle hold", v, 100);
        run_for(37, 0);
        rd(8, v);  check(v == 137, "R2 run", v, 137);
        repeat (5) @(negedge clk);
        rd(8, v);  check(v == 137, "R2 stop hold", v, 137);

        // R3: scaled view for every prescale, write ignored
        wr(8, 32'h5A5A5A);
        for (int s = 0; s < 16; s++) begin
            wr(0, s);
            rd(16, v);
            check(v == ((32'h5A5A5A >> s) & 255), "R3 scaled", v, (32'h5A5A5A >> s) & 255);
        end
        wr(16, 32'h33);
        rd(16, v); check(v == ((32'h5A5A5A >> 15) & 255), "R3 ro", v, (32'h5A5A5A >> 15) & 255);
        rd(8, v);  check(v == 32'h5A5A5A, "R3 count kept", v, 32'h5A5A5A);

        // R4, R8, R9: full sweeps of the 8-bit window
        set_cmps(8'h10, 8'h40, 8'h80, 8'hC0);
        rd(40, v); check(v == 8'h80, "R4 cmp read", v, 8'h80);
        sweep(0, "R4 compare");
        sweep(32'h000F_0000, "R8 center");
        sweep(32'h0F00_0000, "R9 gang");
        sweep(32'h0A05_0000, "R8 R9 mixed");

        // R5: wrap at prescale 0 and 2
        wr(0, 0); wr(8, 250);
        run_for(10, 0);
        rd(8, v); check(v == 4, "R5 wrap s0", v, 4);
        wr(8, 1020);
        run_for(10, 2);
        rd(8, v); check(v == 6, "R5 wrap s2", v, 6);

        // R6: zero on match with compare 0 = 20
        set_cmps(20, 255, 255, 255);
        wr(0, 0); wr(8, 0);
        run_for(50, ZER);
        rd(8, v); check(v == 50 % 21, "R6 zero-on-match", v, 50 % 21);

        // R7: one-shot clears itself and counter rests at 0
        wr(0, 0); wr(8, 250);
        wr(0, ONES);
        repeat (20) @(negedge clk);
        rd(8, v); check(v == 0, "R7 count", v, 0);
        rd(0, v); check(((v >> 13) & 1) == 0, "R7 bit13", (v >> 13) & 1, 0);

        // R10: pending set and software clear
        set_cmps(8'h80, 255, 255, 255);
        wr(8, 0); wr(0, 0);
        check(irq == 4'h0, "R10 cleared", int'(irq), 0);
        wr(8, 8'h90); @(negedge clk);
        check(irq == 4'h1, "R10 set", int'(irq), 1);
        rd(0, v); check(((v >> 28) & 15) == 1, "R10 cfg field", (v >> 28) & 15, 1);

        // R13: clear write while compare hits
        wr(0, 0);
        check(irq == 4'h1, "R13 set wins", int'(irq), 1);
        wr(8, 0); wr(0, 0);
        check(irq == 4'h0, "R10 clear", int'(irq), 0);

        // R11: sticky blocks software
        wr(0, STK | (1 << 28));
        check(irq == 4'h1, "R10 sw load", int'(irq), 1);
        wr(0, STK);
        check(irq == 4'h1, "R11 sticky keep", int'(irq), 1);
        wr(0, 0);
        check(irq == 4'h1, "R11 sticky last", int'(irq), 1);
        wr(0, 0);
        check(irq == 4'h0, "R11 released", int'(irq), 0);

        // R12: deglitch clears at period end; sticky-only keeps
        set_cmps(8'h10, 255, 255, 255);
        wr(0, STK | DGL); wr(8, 0);
        run_for(30, STK | DGL);
        check(irq[0] == 1'b1, "R12 set in period", int'(irq[0]), 1);
        wr(8, 250);
        run_for(7, STK | DGL);
        check(irq[0] == 1'b0, "R12 cleared at wrap", int'(irq[0]), 0);
        rd(8, v); check(v == 1, "R12 count", v, 1);
        wr(0, STK); wr(8, 250);
        run_for(7, STK);
        check(irq[0] == 1'b1, "R11 no deglitch keeps", int'(irq[0]), 1);

        finish_run();
    end
endmodule